// File: doc/BRIEF.md
# Remote Upgrade Register File

This block holds the small register set that steers reconfiguration of a programmable device from a remote-update controller. User logic works through a one-bit serial port. Each enabled edge of the user clock performs one two-bit operation. The operation either moves the 41-bit serial frame by one bit, loads the frame from the internal registers, commits the frame into the staging (update) word, or requests a reconfiguration. The live control word drives the boot address and the watchdog settings directly onto the outputs.

Only the factory image may write the staging word; a write from an application image is dropped. A reconfiguration request crosses into the oscillator domain through a toggle request/acknowledge handshake with two-flop synchronisers. There the staging word becomes the live control word and the request's cause code becomes the status word. After reset the live boot address is either zero or 24'h010000, depending on the boot-scheme input.

Top module: `rcfg_regfile`

## Requirements
- R1: While reset is held, the live boot address becomes 24'h000000 when `parallelScheme` is 0 and 24'h010000 when it is 1. Every other control field, the staging word, the status word and the serial frame reset to zero.
- R2: With `ruEn` high and `ruOp` = 2'b00, the frame shifts right by one bit and `ruDin` enters bit 40. `ruDout` is always frame bit 0, so a frame leaves LSB first.
- R3: With `ruEn` high and `ruOp` = 2'b01, frame bits [40:36] take the status word. Frame bits [35:0] take the staging word when `factoryMode` is 1 and the live control word when it is 0.
- R4: With `ruEn` high, `ruOp` = 2'b10, `factoryMode` = 1 and no reconfiguration in flight, the staging word takes frame bits [35:0].
- R5: A write (`ruOp` = 2'b10) while `factoryMode` is 0 leaves the staging word unchanged.
- R6: With `ruEn` high and `ruOp` = 2'b11, a reconfiguration starts. In the oscillator domain the live control word becomes the staging word and the status word becomes `causeCode`, a one-hot 5-bit code.
- R7: Control word layout: [23:0] boot address, [32:24] watchdog timeout, bit 33 early-done check, bit 34 internal-oscillator select, bit 35 watchdog enable. Each field drives its own output.
- R8: While a reconfiguration is in flight, a further reconfiguration request and a staging-word write are both ignored.
- R9: With `ruEn` low, no operation takes effect, whatever `ruOp` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ruClk | input | 1 | User clock for the frame and the staging word |
| oscClk | input | 1 | Oscillator clock for the control and status words |
| rstN | input | 1 | Asynchronous active-low reset |
| ruEn | input | 1 | Operation enable |
| ruOp | input | 2 | 00 shift, 01 capture/read, 10 write staging word, 11 reconfigure |
| ruDin | input | 1 | Serial data in |
| ruDout | output | 1 | Serial data out (frame bit 0) |
| factoryMode | input | 1 | 1 while the factory image runs |
| parallelScheme | input | 1 | Boot scheme select for the reset address |
| causeCode | input | 5 | One-hot cause recorded by a reconfiguration |
| bootAddr | output | 24 | Live boot address |
| wdTimeout | output | 9 | Watchdog timeout setting |
| wdEnable | output | 1 | Watchdog enable |
| earlyDoneChk | output | 1 | Early configuration-done check option |
| intOscSel | output | 1 | Internal oscillator as startup clock |

## Verification
Two functions can fall in the same window: a reconfiguration commit that is still crossing into the oscillator domain, and a new staging-word write or second trigger issued on the user side. The bench triggers with one cause and, on the very next user-clock edges, issues a write of a different frame and a second trigger with another cause. After the handshake settles, it expects the outputs, the status word and the staging word read back through the frame to show the first request only.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam int ADDR_W  = 24;
  localparam int TMO_W   = 9;
  localparam int CAUSE_W = 5;
  localparam int CTRL_W  = ADDR_W + TMO_W + 3;
  localparam int SHIFT_W = CTRL_W + CAUSE_W;

  typedef enum logic [1:0] {
    OP_SHIFT    = 2'b00,
    OP_CAPTURE  = 2'b01,
    OP_WRITE    = 2'b10,
    OP_RECONFIG = 2'b11
  } rcfgOp_e;

  typedef struct packed {
    logic              wdEnable;
    logic              intOscSel;
    logic              earlyDoneChk;
    logic [TMO_W-1:0]  wdTimeout;
    logic [ADDR_W-1:0] bootAddr;
  } ctrlWord_t;

  typedef struct packed {
    logic shiftEn;
    logic captureEn;
    logic writeEn;
    logic launchEn;
  } ruStrobe_t;
endpackage

// File: rtl/rcfg_ctrl.sv
module rcfg_ctrl
  import rcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      ruClk,
  input  logic      oscClk,
  input  logic      rstN,
  input  logic      ruEn,
  input  logic [1:0] ruOp,
  input  logic      factoryMode,
  output ruStrobe_t strobe,
  output logic      commitEn,
  output logic      busy
);
  localparam int TOP = SYNC_STAGES - 1;

  logic                   reqTgl;
  logic                   reqDone;
  logic [SYNC_STAGES-1:0] reqSync;
  logic [SYNC_STAGES-1:0] ackSync;

  assign busy = reqTgl != ackSync[TOP];

  always_comb begin
    strobe = '0;
    if (ruEn) begin
      case (rcfgOp_e'(ruOp))
        OP_SHIFT:    strobe.shiftEn   = 1'b1;
        OP_CAPTURE:  strobe.captureEn = 1'b1;
        OP_WRITE:    strobe.writeEn   = factoryMode && !busy;
        OP_RECONFIG: strobe.launchEn  = !busy;
        default:     strobe = '0;
      endcase
    end
  end

  always_ff @(posedge ruClk or negedge rstN) begin
    if (!rstN) begin
      reqTgl  <= 1'b0;
      ackSync <= '0;
    end else begin
      if (strobe.launchEn) reqTgl <= ~reqTgl;
      ackSync <= {ackSync[TOP-1:0], reqDone};
    end
  end

  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      reqSync <= '0;
      reqDone <= 1'b0;
    end else begin
      reqSync <= {reqSync[TOP-1:0], reqTgl};
      reqDone <= reqSync[TOP];
    end
  end

  assign commitEn = reqSync[TOP] != reqDone;
endmodule

// File: rtl/rcfg_datapath.sv
module rcfg_datapath
  import rcfg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PAR_BOOT_ADDR = 24'h010000
) (
  input  logic               ruClk,
  input  logic               oscClk,
  input  logic               rstN,
  input  ruStrobe_t          strobe,
  input  logic               commitEn,
  input  logic               ruDin,
  input  logic               factoryMode,
  input  logic               parallelScheme,
  input  logic [CAUSE_W-1:0] causeCode,
  output logic               ruDout,
  output logic [SHIFT_W-1:0] shiftWord,
  output ctrlWord_t          updWord,
  output ctrlWord_t          ctrlWord,
  output logic [CAUSE_W-1:0] statusWord
);
  ctrlWord_t          resetWord;
  logic [CAUSE_W-1:0] pendCause;

  always_comb begin
    resetWord          = '0;
    resetWord.bootAddr = parallelScheme ? PAR_BOOT_ADDR : '0;
  end

  // user-clock side: serial frame, staging word, latched cause
  always_ff @(posedge ruClk or negedge rstN) begin
    if (!rstN) begin
      shiftWord <= '0;
      updWord   <= '0;
      pendCause <= '0;
    end else begin
      if (strobe.shiftEn)
        shiftWord <= {ruDin, shiftWord[SHIFT_W-1:1]};
      else if (strobe.captureEn)
        shiftWord <= {statusWord, factoryMode ? updWord : ctrlWord};
      if (strobe.writeEn)  updWord   <= ctrlWord_t'(shiftWord[CTRL_W-1:0]);
      if (strobe.launchEn) pendCause <= causeCode;
    end
  end

  // oscillator side: live control word and status
  always_ff @(posedge oscClk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord   <= resetWord;
      statusWord <= '0;
    end else if (commitEn) begin
      ctrlWord   <= updWord;
      statusWord <= pendCause;
    end
  end

  assign ruDout = shiftWord[0];
endmodule

// File: rtl/rcfg_regfile.sv
module rcfg_regfile
  import rcfg_pkg::*;
#(
  parameter int                SYNC_STAGES   = 2,
  parameter logic [ADDR_W-1:0] PAR_BOOT_ADDR = 24'h010000
) (
  input  logic               ruClk,
  input  logic               oscClk,
  input  logic               rstN,
  input  logic               ruEn,
  input  logic [1:0]         ruOp,
  input  logic               ruDin,
  output logic               ruDout,
  input  logic               factoryMode,
  input  logic               parallelScheme,
  input  logic [CAUSE_W-1:0] causeCode,
  output logic [ADDR_W-1:0]  bootAddr,
  output logic [TMO_W-1:0]   wdTimeout,
  output logic               wdEnable,
  output logic               earlyDoneChk,
  output logic               intOscSel
);
  ruStrobe_t          strobe;
  logic               commitEn;
  logic               busy;
  logic [SHIFT_W-1:0] shiftWord;
  ctrlWord_t          updWord;
  ctrlWord_t          ctrlWord;
  logic [CAUSE_W-1:0] statusWord;

  rcfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .ruClk(ruClk), .oscClk(oscClk), .rstN(rstN), .ruEn(ruEn), .ruOp(ruOp),
    .factoryMode(factoryMode), .strobe(strobe), .commitEn(commitEn), .busy(busy)
  );

  rcfg_datapath #(.PAR_BOOT_ADDR(PAR_BOOT_ADDR)) u_dp (
    .ruClk(ruClk), .oscClk(oscClk), .rstN(rstN), .strobe(strobe),
    .commitEn(commitEn), .ruDin(ruDin), .factoryMode(factoryMode),
    .parallelScheme(parallelScheme), .causeCode(causeCode), .ruDout(ruDout),
    .shiftWord(shiftWord), .updWord(updWord), .ctrlWord(ctrlWord),
    .statusWord(statusWord)
  );

  assign bootAddr     = ctrlWord.bootAddr;
  assign wdTimeout    = ctrlWord.wdTimeout;
  assign wdEnable     = ctrlWord.wdEnable;
  assign earlyDoneChk = ctrlWord.earlyDoneChk;
  assign intOscSel    = ctrlWord.intOscSel;
endmodule

// File: rtl/rcfg_regfile_chk.sv
module rcfg_regfile_chk (
  input logic        ruClk,
  input logic        oscClk,
  input logic        rstN,
  input logic        ruEn,
  input logic [1:0]  ruOp,
  input logic        ruDin,
  input logic        factoryMode,
  input logic [40:0] shiftWord,
  input logic [35:0] updWord,
  input logic [35:0] ctrlWord,
  input logic [4:0]  statusWord,
  input logic        busy,
  input logic        commitEn
);
  // R2
  shift_move_chk: assert property (@(posedge ruClk) disable iff (!rstN)
    (ruEn && ruOp == 2'b00) |=> shiftWord == {$past(ruDin), $past(shiftWord[40:1])});

  // R3
  capture_status_chk: assert property (@(posedge ruClk) disable iff (!rstN)
    (ruEn && ruOp == 2'b01) |=> shiftWord[40:36] == $past(statusWord));

  // R4
  factory_write_chk: assert property (@(posedge ruClk) disable iff (!rstN)
    (ruEn && ruOp == 2'b10 && factoryMode && !busy) |=> updWord == $past(shiftWord[35:0]));

  // R5
  app_write_ignored_chk: assert property (@(posedge ruClk) disable iff (!rstN)
    (ruEn && ruOp == 2'b10 && !factoryMode) |=> $stable(updWord));

  // R8
  busy_write_ignored_chk: assert property (@(posedge ruClk) disable iff (!rstN)
    (ruEn && ruOp == 2'b10 && busy) |=> $stable(updWord));

  // R6
  busy_source_chk: assert property (@(posedge ruClk) disable iff (!rstN)
    $rose(busy) |-> $past(ruEn && ruOp == 2'b11));

  // R9
  idle_hold_chk: assert property (@(posedge ruClk) disable iff (!rstN)
    !ruEn |=> $stable(shiftWord) && $stable(updWord));

  // R6
  ctrl_commit_only_chk: assert property (@(posedge oscClk) disable iff (!rstN)
    (ctrlWord != $past(ctrlWord) || statusWord != $past(statusWord)) |-> $past(commitEn));
endmodule

bind rcfg_regfile rcfg_regfile_chk i_chk (
  .ruClk(ruClk), .oscClk(oscClk), .rstN(rstN), .ruEn(ruEn), .ruOp(ruOp),
  .ruDin(ruDin), .factoryMode(factoryMode), .shiftWord(shiftWord),
  .updWord(updWord), .ctrlWord(ctrlWord), .statusWord(statusWord),
  .busy(busy), .commitEn(commitEn)
);

// File: tb/test_rcfg_regfile.sv
module test_rcfg_regfile;
  logic        ruClk = 1'b0;
  logic        oscClk = 1'b0;
  logic        rstN = 1'b0;
  logic        ruEn = 1'b0;
  logic [1:0]  ruOp = 2'b00;
  logic        ruDin = 1'b0;
  logic        ruDout;
  logic        factoryMode = 1'b0;
  logic        parallelScheme = 1'b1;
  logic [4:0]  causeCode = 5'b0;
  logic [23:0] bootAddr;
  logic [8:0]  wdTimeout;
  logic        wdEnable, earlyDoneChk, intOscSel;
  logic        obsValid = 1'b0;

  int nTests = 0;
  int nFail  = 0;

  typedef struct {
    logic [40:0] word;
    string       req;
  } expItem_t;
  expItem_t expQ[$];

  // bit35 wdEn, 34 intOsc, 33 earlyDone, [32:24] timeout, [23:0] address
  localparam logic [35:0] W1 = {1'b0, 1'b1, 1'b0, 9'h0AB, 24'h123456};
  localparam logic [35:0] W2 = 36'h5_5555_5555;
  localparam logic [35:0] W3 = {1'b1, 1'b0, 1'b1, 9'h155, 24'hABCDEF};
  localparam logic [35:0] W4 = 36'hC_3C3C_3C3C;

  always #5  ruClk  = ~ruClk;
  always #20 oscClk = ~oscClk;

  rcfg_regfile i_rcfg_regfile (
    .ruClk(ruClk), .oscClk(oscClk), .rstN(rstN), .ruEn(ruEn), .ruOp(ruOp),
    .ruDin(ruDin), .ruDout(ruDout), .factoryMode(factoryMode),
    .parallelScheme(parallelScheme), .causeCode(causeCode), .bootAddr(bootAddr),
    .wdTimeout(wdTimeout), .wdEnable(wdEnable), .earlyDoneChk(earlyDoneChk),
    .intOscSel(intOscSel)
  );

  // monitor: assemble 41 serial bits, compare against the scoreboard head
  logic [40:0] gotWord;
  int          nBits = 0;
  always @(negedge ruClk) begin
    if (obsValid) begin
      gotWord[nBits] = ruDout;
      nBits++;
      if (nBits == 41) begin
        nBits = 0;
        nTests++;
        if (expQ.size() == 0) begin
          nFail++;
          $display("FAIL scoreboard: unexpected frame actual=%h expected=none", gotWord);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          if (gotWord !== it.word) begin
            nFail++;
            $display("FAIL %s: frame actual=%h expected=%h", it.req, gotWord, it.word);
          end
        end
      end
    end
  end

  task automatic drive(input logic en, input logic [1:0] code, input logic din, input logic obs);
    @(posedge ruClk);
    #1;
    ruEn = en; ruOp = code; ruDin = din; obsValid = obs;
  endtask

  task automatic idle(input int n);
    drive(1'b0, 2'b00, 1'b0, 1'b0);
    repeat (n) @(posedge ruClk);
  endtask

  task automatic loadShift(input logic [40:0] w);
    for (int i = 0; i < 41; i++) drive(1'b1, 2'b00, w[i], 1'b0);
    drive(1'b0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic readOut(input logic [40:0] w, input string req);
    expItem_t it;
    it.word = w; it.req = req;
    expQ.push_back(it);
    for (int i = 0; i < 41; i++) drive(1'b1, 2'b00, 1'b0, 1'b1);
    drive(1'b0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic captureRead(input logic [40:0] w, input string req);
    drive(1'b1, 2'b01, 1'b0, 1'b0);
    readOut(w, req);
  endtask

  task automatic checkOuts(input logic [35:0] w, input string req);
    logic [35:0] act;
    act = {wdEnable, intOscSel, earlyDoneChk, wdTimeout, bootAddr};
    nTests++;
    if (act !== w) begin
      nFail++;
      $display("FAIL %s: outputs actual=%h expected=%h", req, act, w);
    end
  endtask

  task automatic doReset(input logic par);
    rstN = 1'b0;
    parallelScheme = par;
    drive(1'b0, 2'b00, 1'b0, 1'b0);
    repeat (6) @(posedge ruClk);
    #1 rstN = 1'b1;
    #3;
  endtask

  initial begin : main
    // R1: parallel scheme reset
    doReset(1'b1);
    checkOuts({12'h0, 24'h010000}, "R1 parallel reset");
    readOut(41'h0, "R1 frame reset");
    factoryMode = 1'b0;
    captureRead({5'h0, 12'h0, 24'h010000}, "R1/R3 app capture of reset control");
    // R1: serial scheme reset
    doReset(1'b0);
    checkOuts(36'h0, "R1 serial reset");
    factoryMode = 1'b1;
    captureRead(41'h0, "R1/R3 factory capture of reset staging");

    // R2: shift-through LSB first
    loadShift({5'h1F, W2});
    readOut({5'h1F, W2}, "R2 shift through");

    // R4: factory write, R3 factory read
    loadShift({5'h0A, W1});
    drive(1'b1, 2'b10, 1'b0, 1'b0);
    idle(1);
    captureRead({5'h0, W1}, "R4/R3 factory staging readback");

    // R6, R7: trigger and commit
    causeCode = 5'b00100;
    drive(1'b1, 2'b11, 1'b0, 1'b0);
    idle(30);
    checkOuts(W1, "R6/R7 control outputs after reconfig");
    factoryMode = 1'b0;
    captureRead({5'b00100, W1}, "R6/R3 app capture control+status");

    // R5: application write ignored
    loadShift({5'h1F, W2});
    drive(1'b1, 2'b10, 1'b0, 1'b0);
    drive(1'b0, 2'b00, 1'b0, 1'b0);
    factoryMode = 1'b1;
    captureRead({5'b00100, W1}, "R5 app write ignored");

    // R9: enable low does nothing
    loadShift({5'h1F, W2});
    causeCode = 5'b10000;
    drive(1'b0, 2'b10, 1'b0, 1'b0);
    drive(1'b0, 2'b11, 1'b0, 1'b0);
    drive(1'b0, 2'b01, 1'b0, 1'b0);
    idle(30);
    checkOuts(W1, "R9 outputs hold with enable low");
    readOut({5'h1F, W2}, "R9 frame held with enable low");
    captureRead({5'b00100, W1}, "R9 staging held with enable low");

    // R8: collisions with an in-flight reconfiguration
    loadShift({5'h00, W3});
    drive(1'b1, 2'b10, 1'b0, 1'b0);
    idle(1);
    loadShift({5'h00, W4});
    causeCode = 5'b00010;
    drive(1'b1, 2'b11, 1'b0, 1'b0);
    drive(1'b1, 2'b10, 1'b0, 1'b0);
    causeCode = 5'b10000;
    drive(1'b1, 2'b11, 1'b0, 1'b0);
    idle(30);
    checkOuts(W3, "R8/R7 first request only");
    captureRead({5'b00010, W3}, "R8 staging and status from first request");

    // R4 again after settle: write accepted once not busy
    loadShift({5'h00, W4});
    drive(1'b1, 2'b10, 1'b0, 1'b0);
    idle(1);
    captureRead({5'b00010, W4}, "R4 write accepted after settle");

    idle(5);
    wait (expQ.size() == 0);
    #20;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : watchdog
    repeat (50000) @(posedge ruClk);
    nTests++;
    nFail++;
    $display("FAIL watchdog: run hung actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule